// File: doc/BRIEF.md
# LIN Bus Remote Wake-Up Detector

This block watches the synchronised LIN receive level while the transceiver is in one of its low-power modes and decides whether a remote node has asked the bus to wake. A wake is accepted only for a complete dominant pulse: the bus falls, stays dominant for at least a programmable number of timing ticks, and then returns to recessive. The wake is taken at that closing rising edge. A short glitch does not wake the node, and neither does a bus held dominant indefinitely, until the bus is released.

The mode controller raises `armed` while the device sleeps or is silent. `tick` is a single-cycle strobe from a shared timebase, and the filter length is given in those ticks. For example, 90 ticks of 1 µs sit inside the 30 to 150 µs window. On acceptance the block emits a one-cycle `wake_pulse` and sets `wake_flag`. The flag holds the host-facing receive output `rxd_out` low as an interrupt until `armed` is withdrawn.

Top module: `lin_wake_detect`

## Requirements
- R1: After reset, `wake_pulse` and `wake_flag` are 0 and `rxd_out` is 1.
- R2: While armed, a falling edge followed by at least FILTER_TICKS `tick` strobes counted while the bus stays dominant (`bus_level`=0) and then a rising edge produces a wake. `wake_pulse` and `wake_flag` go high at the clock edge that samples the bus back at recessive (`bus_level`=1).
- R3: A dominant pulse that collects fewer than FILTER_TICKS strobes before the bus returns recessive produces no wake. The detector goes back to idle, so the next valid pulse is accepted.
- R4: While the bus stays dominant, no wake is signalled however long it lasts. The wake appears only once the bus returns recessive.
- R5: The dominant tick counter saturates at FILTER_TICKS and never wraps. A pulse of any length at or above the threshold wakes, including lengths that are a multiple of the counter's natural range.
- R6: `wake_pulse` is high for exactly one clock cycle. Only one wake is reported per armed period, and further valid pulses give no new pulse.
- R7: `wake_flag` stays set while `armed` is high. Dropping `armed` clears the flag within one clock and discards any partial dominant count.
- R8: While `armed` is low, bus activity is ignored. If `armed` rises with the bus already dominant, no falling edge has been seen, so the later release produces no wake.
- R9: `rxd_out` is 0 exactly when `wake_flag` is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| armed | input | 1 | High while a low-power mode permits remote wake |
| bus_level | input | 1 | Synchronised bus level, 1 = recessive, 0 = dominant |
| tick | input | 1 | One-cycle timebase strobe counted during dominant |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_flag | output | 1 | Latched wake, cleared by dropping `armed` |
| rxd_out | output | 1 | Host receive line, held low by a latched wake |

## Verification
The assertions take for granted that `bus_level` is already synchronised to `clk` and changes at most once per cycle. They also assume `tick` is a single-cycle strobe. The stimulus drives every input at the falling clock edge and raises `tick` for one cycle at a time, only while the bus is held dominant. It waits two cycles after each falling edge before the first strobe and one cycle after the last strobe before the release. Random pulse lengths are drawn on both sides of the threshold, and `armed` is dropped at random points.

// File: rtl/lwd_pkg.sv
// Package: shared types for the LIN wake detector.
// Assumes: nothing beyond IEEE 1800-2017.
package lwd_pkg;
    // Detector phases: waiting for a fall, timing dominant, wake taken
    typedef enum logic [1:0] {
        LWD_IDLE = 2'd0,
        LWD_LOW  = 2'd1,
        LWD_DONE = 2'd2
    } lwd_state_t;
endpackage

// File: rtl/lwd_edge.sv
// Module: lwd_edge
// Registers the bus level and flags falling and rising transitions.
// Assumes: bus_level is already synchronised to clk; recessive after reset.
module lwd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_level,
    output logic bus_q,
    output logic fall,
    output logic rise
);
    // Hold last sampled level, recessive out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= 1'b1;
        else        bus_q <= bus_level;
    end

    // Transition decode against the previous sample
    always_comb begin
        fall = bus_q & ~bus_level;
        rise = ~bus_q & bus_level;
    end
endmodule

// File: rtl/lwd_dom_timer.sv
// Module: lwd_dom_timer
// Counts tick strobes while enabled, saturating at FILTER_TICKS.
// Assumes: clear has priority; tick is a one-cycle strobe.
module lwd_dom_timer #(
    parameter int FILTER_TICKS = 90,
    localparam int CW = $clog2(FILTER_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic          reached
);
    localparam logic [CW-1:0] LIMIT = CW'(FILTER_TICKS);

    logic sat;

    // Saturation and threshold flags from the current count
    always_comb begin
        sat     = (cnt >= LIMIT);
        reached = sat;
    end

    // Dominant tick counter, held at the limit instead of wrapping
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (clear)                cnt <= '0;
        else if (run && tick && !sat)  cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/lwd_fsm.sv
// Module: lwd_fsm
// Sequences fall / dominant / rise and produces the wake pulse and flag.
// Assumes: fall/rise come from lwd_edge; reached from lwd_dom_timer.
module lwd_fsm
    import lwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic       bus_level,
    input  logic       fall,
    input  logic       rise,
    input  logic       reached,
    output logic       cnt_clear,
    output logic       cnt_run,
    output logic       wake_pulse,
    output logic       wake_flag,
    output lwd_state_t state
);
    lwd_state_t state_nx;
    logic       accept;

    // Next phase and acceptance decision
    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        if (!armed) begin
            state_nx = LWD_IDLE;
        end else begin
            unique case (state)
                LWD_IDLE: if (fall) state_nx = LWD_LOW;
                LWD_LOW: begin
                    if (rise) begin
                        if (reached) begin
                            state_nx = LWD_DONE;
                            accept   = 1'b1;
                        end else begin
                            state_nx = LWD_IDLE;
                        end
                    end
                end
                LWD_DONE: state_nx = LWD_DONE;
                default:  state_nx = LWD_IDLE;
            endcase
        end
    end

    // Counter control: run only while timing a dominant level
    always_comb begin
        cnt_run   = (state == LWD_LOW) && !bus_level && armed;
        cnt_clear = (state != LWD_LOW) || !armed;
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LWD_IDLE;
        else        state <= state_nx;
    end

    // Wake outputs: single-cycle pulse, flag held until disarmed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_pulse <= 1'b0;
            wake_flag  <= 1'b0;
        end else if (!armed) begin
            wake_pulse <= 1'b0;
            wake_flag  <= 1'b0;
        end else begin
            wake_pulse <= accept;
            if (accept) wake_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/lin_wake_detect.sv
// Module: lin_wake_detect (top)
// Remote wake detection on the LIN receive level during low-power modes.
// Assumes: bus_level synchronised; tick single-cycle; FILTER_TICKS >= 1.
module lin_wake_detect #(
    parameter int FILTER_TICKS = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic bus_level,
    input  logic tick,
    output logic wake_pulse,
    output logic wake_flag,
    output logic rxd_out
);
    import lwd_pkg::*;
    localparam int CW = $clog2(FILTER_TICKS + 1);

    logic          bus_q, fall, rise;
    logic          cnt_clear, cnt_run, reached;
    logic [CW-1:0] dom_cnt;
    lwd_state_t    state;

    lwd_edge u_edge (
        .clk(clk), .rst_n(rst_n), .bus_level(bus_level),
        .bus_q(bus_q), .fall(fall), .rise(rise)
    );

    lwd_dom_timer #(.FILTER_TICKS(FILTER_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .run(cnt_run),
        .tick(tick), .cnt(dom_cnt), .reached(reached)
    );

    lwd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .armed(armed), .bus_level(bus_level),
        .fall(fall), .rise(rise), .reached(reached),
        .cnt_clear(cnt_clear), .cnt_run(cnt_run),
        .wake_pulse(wake_pulse), .wake_flag(wake_flag), .state(state)
    );

    // Host receive line pulled low by a latched wake
    always_comb rxd_out = ~wake_flag;
endmodule

// File: rtl/lwd_checks.sv
// Module: lwd_checks
// Property checker for lin_wake_detect, attached by bind below.
// Assumes: synchronous active-low reset; inputs change once per cycle.
module lwd_checks #(
    parameter int FILTER_TICKS = 90,
    localparam int CW = $clog2(FILTER_TICKS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          armed,
    input logic          bus_level,
    input logic          wake_pulse,
    input logic          wake_flag,
    input logic          rxd_out,
    input logic [CW-1:0] cnt
);
    p_pulse_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    p_pulse_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> wake_flag);

    p_flag_from_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> wake_pulse);

    p_wake_on_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(bus_level));

    p_disarm_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !wake_flag);

    p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && armed) |=> wake_flag);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(FILTER_TICKS));

    p_rxd_low_on_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pulse) |-> !rxd_out);
endmodule

bind lin_wake_detect lwd_checks #(.FILTER_TICKS(FILTER_TICKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .armed(armed), .bus_level(bus_level),
    .wake_pulse(wake_pulse), .wake_flag(wake_flag), .rxd_out(rxd_out),
    .cnt(dom_cnt)
);

// File: tb/sim_lin_wake_detect.sv
module sim_lin_wake_detect;
    localparam int CLK_PERIOD = 10;
    localparam int T = 8;

    logic clk = 1'b0, rst_n = 1'b0, armed = 1'b0, bus_level = 1'b1, tick = 1'b0;
    logic wake_pulse, wake_flag, rxd_out;
    int   n_run = 0, n_fail = 0;
    bit   exp_flag = 1'b0;
    bit   done = 1'b0;

    lin_wake_detect #(.FILTER_TICKS(T)) u0 (
        .clk(clk), .rst_n(rst_n), .armed(armed), .bus_level(bus_level),
        .tick(tick), .wake_pulse(wake_pulse), .wake_flag(wake_flag),
        .rxd_out(rxd_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_wake(input int n, input bit armed_now, input bit flag_before);
        return armed_now && !flag_before && (n >= T);
    endfunction

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    // Full dominant pulse with n strobes; returns pulse at release, one later, flag
    task automatic dom_pulse(input int n, output bit p1, output bit p2, output bit f);
        @(negedge clk) bus_level = 1'b0;
        repeat (2) @(negedge clk);
        ticks(n);
        @(negedge clk) bus_level = 1'b1;
        @(negedge clk) begin p1 = wake_pulse; f = wake_flag; end
        @(negedge clk) p2 = wake_pulse;
    endtask

    task automatic disarm_rearm();
        @(negedge clk) armed = 1'b0;
        @(negedge clk) armed = 1'b1;
        exp_flag = 1'b0;
    endtask

    task automatic run_pulse(input string req, input int n);
        bit p1, p2, f, e;
        e = exp_wake(n, armed, exp_flag);
        dom_pulse(n, p1, p2, f);
        exp_flag = exp_flag | e;
        chk(req, "wake_pulse at release", int'(p1), int'(e));
        chk("R6", "wake_pulse next cycle", int'(p2), 0);
        chk(req, "wake_flag", int'(f), int'(exp_flag));
        chk("R9", "rxd_out", int'(rxd_out), int'(!exp_flag));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "wake_pulse", int'(wake_pulse), 0);
        chk("R1", "wake_flag", int'(wake_flag), 0);
        chk("R1", "rxd_out", int'(rxd_out), 1);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk) armed = 1'b1;

        // R2: exactly threshold
        run_pulse("R2", T);
        disarm_rearm();
        chk("R7", "flag cleared by disarm", int'(wake_flag), 0);
        // R3: one short, then a valid pulse still accepted
        run_pulse("R3", T-1);
        run_pulse("R3", 1);
        run_pulse("R3", T);
        // R6: second valid pulse in same armed period
        run_pulse("R6", T+3);
        chk("R7", "flag held", int'(wake_flag), 1);
        disarm_rearm();
        // R5: lengths equal to counter range multiples
        run_pulse("R5", 16);
        disarm_rearm();
        run_pulse("R5", 32);
        disarm_rearm();
        // R4: stuck dominant
        @(negedge clk) bus_level = 1'b0;
        repeat (2) @(negedge clk);
        ticks(5*T);
        repeat (20) @(negedge clk);
        chk("R4", "flag while stuck", int'(wake_flag), 0);
        chk("R4", "rxd while stuck", int'(rxd_out), 1);
        @(negedge clk) bus_level = 1'b1;
        @(negedge clk);
        chk("R4", "pulse on release", int'(wake_pulse), 1);
        chk("R4", "flag on release", int'(wake_flag), 1);
        exp_flag = 1'b1;
        disarm_rearm();
        // R7: disarm mid-pulse discards count
        @(negedge clk) bus_level = 1'b0;
        repeat (2) @(negedge clk);
        ticks(T);
        @(negedge clk) armed = 1'b0;
        @(negedge clk) armed = 1'b1;
        @(negedge clk) bus_level = 1'b1;
        @(negedge clk);
        chk("R7", "no wake after mid-pulse disarm", int'(wake_flag), 0);
        // R8: disarmed pulse ignored
        @(negedge clk) armed = 1'b0;
        run_pulse("R8", T+2);
        chk("R8", "disarmed flag", int'(wake_flag), 0);
        // R8: armed while already dominant
        @(negedge clk) bus_level = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk) armed = 1'b1;
        ticks(T+2);
        @(negedge clk) bus_level = 1'b1;
        @(negedge clk);
        chk("R8", "no fall seen, pulse", int'(wake_pulse), 0);
        chk("R8", "no fall seen, flag", int'(wake_flag), 0);

        // Random mix
        for (int k = 0; k < 60; k++) begin
            int n;
            n = int'($urandom_range(0, 2*T + 4));
            if ($urandom_range(0, 2) == 0) disarm_rearm();
            run_pulse(n >= T ? "R2" : "R3", n);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule